// File: doc/BRIEF.md
# Serial Flash Erase Command Sequencer

This block sits on the host side of a serial flash link and sends one erase command per request. A request names the erase size (a single page, or a block of eight pages), a 12-bit page number and the page-size mode of the device: either 528-byte pages or binary 512-byte pages. The sequencer assembles a 32-bit frame from an opcode byte and a three-byte address field. In that address field the page number sits at a bit position that depends on the mode and on the erase size, with zero padding before and after it.

The frame is shifted out most significant bit first in SPI mode 0. SCK is derived from the system clock by an even divider. Chip select is driven low for exactly 32 SCK pulses and is released on that byte boundary, which is the moment the device starts erasing. A request/ready handshake paces the host. Ready stays low from acceptance until chip select has been high for one full SCK period, so the next command can never violate the deselect time.

Top module: `flash_erase_seq`

## Requirements
- R1: The first byte sent is the opcode: 0x81 when `req_block` is 0 (page erase) and 0x50 when `req_block` is 1 (block erase).
- R2: For a page erase with `req_bin_page` = 0 (528-byte pages), the 24 address bits are 2 zero bits, then `req_page[11:0]`, then 10 zero bits.
- R3: For a page erase with `req_bin_page` = 1 (512-byte pages), the address bits are 3 zero bits, then `req_page[11:0]`, then 9 zero bits.
- R4: For a block erase with `req_bin_page` = 0, the address bits are 2 zero bits, then `req_page[11:3]`, then 13 zero bits. The three low page bits have no effect.
- R5: For a block erase with `req_bin_page` = 1, the address bits are 3 zero bits, then `req_page[11:3]`, then 12 zero bits.
- R6: Bits go out MSB first in SPI mode 0. SCK idles low. Each bit holds SCK low for SCK_DIV/2 system clocks and then high for SCK_DIV/2 system clocks. MOSI changes only while SCK is low, and only as SCK falls or as CS_n falls.
- R7: CS_n falls on the clock edge that accepts a request. It stays low for exactly 32 SCK rising edges and rises SCK_DIV/2 clocks after the last SCK falling edge, with SCK low.
- R8: `req_ready` drops on the accepting edge. It returns high 67·SCK_DIV/2 clocks after that edge, which leaves CS_n high for SCK_DIV clocks first. A request held valid is taken on the first edge at which ready is high.
- R9: A request presented while `req_ready` is low is ignored. The frame in flight and the command timing stay unchanged.
- R10: During reset, and after it, CS_n is high, SCK is low, MOSI is 0 and `req_ready` is high. MOSI is 0 whenever CS_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_block | input | 1 | 1 = eight-page block erase, 0 = single-page erase |
| req_bin_page | input | 1 | 1 = 512-byte page mode, 0 = 528-byte page mode |
| req_page | input | PAGE_W | Page number to erase |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |

## Verification
The bench builds the sequencer with SCK_DIV = 4, so each SCK half-period lasts two system clocks. This lets the phase counter wrap inside every half-period while one command still fits in 134 clocks, so many commands run in a short time. The default page width of 12 and block size of eight pages are kept. With these values all four mode and erase-size packings can be driven with all-ones, all-zeros and mixed page numbers, including ones whose low three bits must be dropped. The bench also drives back-to-back requests held valid, and stray requests that arrive mid-command.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   localparam int OPC_W  = 8;
   localparam int ADDR_W = 24;

   localparam logic [OPC_W-1:0] OPC_PAGE_ERASE  = 8'h81;
   localparam logic [OPC_W-1:0] OPC_BLOCK_ERASE = 8'h50;

   // leading pad bits ahead of the page field, per page-size mode
   localparam int LEAD_STD = 2;
   localparam int LEAD_BIN = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_TAIL,
      ST_GAP
   } seq_state_t;

endpackage

// File: rtl/erase_frame_pack.sv
module erase_frame_pack
   import erase_seq_pkg::*;
#(
   parameter int PAGE_W   = 12,
   parameter int BLK_LOG2 = 3,
   localparam int FRAME_W = OPC_W + ADDR_W
)(
   input  logic              is_block,
   input  logic              is_bin,
   input  logic [PAGE_W-1:0] page,
   output logic [FRAME_W-1:0] frame
);

   localparam int TRAIL_STD = ADDR_W - LEAD_STD - PAGE_W;
   localparam int TRAIL_BIN = ADDR_W - LEAD_BIN - PAGE_W;

   generate
      if (TRAIL_BIN < 0)
         $error("page field does not fit in the address bytes");
      if (BLK_LOG2 < 1 || BLK_LOG2 >= PAGE_W)
         $error("block size out of range");
   endgenerate

   localparam logic [PAGE_W-1:0] BLK_KEEP =
      {{(PAGE_W-BLK_LOG2){1'b1}}, {BLK_LOG2{1'b0}}};

   logic [PAGE_W-1:0] page_field;
   logic [ADDR_W-1:0] page_wide;
   logic [ADDR_W-1:0] addr;
   logic [OPC_W-1:0]  opcode;

   always_comb begin
      page_field = is_block ? (page & BLK_KEEP) : page;
      page_wide  = ADDR_W'(page_field);
      addr       = is_bin ? (page_wide << TRAIL_BIN) : (page_wide << TRAIL_STD);
      opcode     = is_block ? OPC_BLOCK_ERASE : OPC_PAGE_ERASE;
      frame      = {opcode, addr};
   end

endmodule

// File: rtl/sck_phase_timer.sv
module sck_phase_timer #(
   parameter int HALF = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic phase_end
);

   generate
      if (HALF < 1) begin : g_bad
         $error("half period must be at least one clock");
      end
      if (HALF == 1) begin : g_direct
         assign phase_end = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run)
               cnt <= '0;
            else if (cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign phase_end = run && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
   parameter int FRAME_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               shift,
   output logic               msb,
   output logic               last_bit
);

   localparam int IW = $clog2(FRAME_W);
   localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_W - 1);

   logic [FRAME_W-1:0] shreg;
   logic [IW-1:0]      idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         idx   <= '0;
      end else if (load) begin
         shreg <= load_val;
         idx   <= '0;
      end else if (shift) begin
         shreg <= {shreg[FRAME_W-2:0], 1'b0};
         idx   <= idx + 1'b1;
      end
   end

   assign msb      = shreg[FRAME_W-1];
   assign last_bit = (idx == LAST_IDX);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import erase_seq_pkg::*;
#(
   parameter int SCK_DIV  = 4,
   parameter int PAGE_W   = 12,
   parameter int BLK_LOG2 = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_block,
   input  logic              req_bin_page,
   input  logic [PAGE_W-1:0] req_page,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi
);

   localparam int HALF    = SCK_DIV / 2;
   localparam int FRAME_W = OPC_W + ADDR_W;

   generate
      if (SCK_DIV < 2 || (SCK_DIV % 2) != 0)
         $error("SCK_DIV must be even and at least 2");
   endgenerate

   seq_state_t         state;
   logic               gap_second;
   logic               accept;
   logic               phase_end;
   logic               msb;
   logic               last_bit;
   logic               do_shift;
   logic [FRAME_W-1:0] frame;

   assign accept   = req_valid && (state == ST_IDLE);
   assign do_shift = (state == ST_HIGH) && phase_end && !last_bit;

   erase_frame_pack #(
      .PAGE_W   (PAGE_W),
      .BLK_LOG2 (BLK_LOG2)
   ) u_pack (
      .is_block (req_block),
      .is_bin   (req_bin_page),
      .page     (req_page),
      .frame    (frame)
   );

   sck_phase_timer #(
      .HALF (HALF)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (state != ST_IDLE),
      .phase_end (phase_end)
   );

   spi_bit_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (frame),
      .shift    (do_shift),
      .msb      (msb),
      .last_bit (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         gap_second <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (accept) state <= ST_LOW;
            ST_LOW:  if (phase_end) state <= ST_HIGH;
            ST_HIGH: if (phase_end) state <= last_bit ? ST_TAIL : ST_LOW;
            ST_TAIL: if (phase_end) begin
               state      <= ST_GAP;
               gap_second <= 1'b0;
            end
            ST_GAP: if (phase_end) begin
               if (gap_second) state <= ST_IDLE;
               else            gap_second <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic selected;
   assign selected  = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);
   assign spi_cs_n  = !selected;
   assign spi_sck   = (state == ST_HIGH);
   assign spi_mosi  = selected && msb;
   assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
   parameter int SCK_DIV = 4,
   parameter int FRAME_W = 32
)(
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic spi_sck,
   input logic spi_cs_n,
   input logic spi_mosi
);

   localparam int RW = $clog2(FRAME_W + 2);
   localparam int GW = $clog2(SCK_DIV + 2);

   logic [RW-1:0] rise_cnt;
   logic [GW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt <= '0;
         hi_cnt   <= GW'(SCK_DIV);
      end else begin
         if (spi_cs_n)
            rise_cnt <= '0;
         else if (spi_sck && !$past(spi_sck))
            rise_cnt <= rise_cnt + 1'b1;
         if (!spi_cs_n)
            hi_cnt <= '0;
         else if (hi_cnt < GW'(SCK_DIV))
            hi_cnt <= hi_cnt + 1'b1;
      end
   end

   // R7
   accept_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !spi_cs_n);

   // R7
   byte_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (rise_cnt == RW'(FRAME_W)) && !spi_sck && !$past(spi_sck));

   // R6
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   // R6
   mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && !$past(spi_cs_n) && (spi_mosi != $past(spi_mosi)))
         |-> $fell(spi_sck));

   // R8
   ready_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> spi_cs_n && (hi_cnt >= GW'(SCK_DIV)));

   // R10
   mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_mosi);

endmodule

bind flash_erase_seq erase_seq_chk #(
   .SCK_DIV (SCK_DIV),
   .FRAME_W (32)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .spi_sck   (spi_sck),
   .spi_cs_n  (spi_cs_n),
   .spi_mosi  (spi_mosi)
);

// File: tb/sim_flash_erase_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_seq;

   localparam int DIV  = 4;
   localparam int H    = DIV / 2;
   localparam int BUSY = 67 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_block = 1'b0;
   logic        req_bin_page = 1'b0;
   logic [11:0] req_page = '0;
   logic        req_ready, spi_sck, spi_cs_n, spi_mosi;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   flash_erase_seq #(.SCK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_block(req_block), .req_bin_page(req_bin_page), .req_page(req_page),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   // expected frame, from the requirement text
   function automatic logic [31:0] want_frame(bit blk, bit bin, int page);
      longint a;
      longint op = blk ? 80 : 129;          // 0x50 / 0x81
      if (blk) a = (page / 8) * (bin ? 4096 : 8192);
      else     a = page * (bin ? 512 : 1024);
      return 32'(op * 16777216 + a);
   endfunction

   // reference model
   int          t = -1;
   logic [31:0] mframe = '0;
   string       drive_tag = "";
   string       mtag = "";
   bit          mvalid_frame = 0;
   bit          cap_q[$];

   always @(posedge clk) begin
      if (!rst_n) t = -1;
      else if (t < 0) begin
         if (req_valid) begin
            mframe = want_frame(req_block, req_bin_page, int'(req_page));
            mtag = drive_tag;
            mvalid_frame = 1;
            cap_q.delete();
            t = 0;
         end
      end else begin
         t++;
         if (t >= BUSY) t = -1;
      end
   end

   bit prev_sck = 0, prev_ready = 1;

   always @(negedge clk) begin
      bit e_cs, e_sck, e_mosi, e_rdy;
      string mtagb;
      cycles++;
      if (rst_n) begin
         e_rdy = (t < 0); e_cs = 1; e_sck = 0; e_mosi = 0;
         if (t >= 0 && t < 64*H) begin
            e_cs = 0; e_sck = ((t % (2*H)) >= H); e_mosi = mframe[31 - t/(2*H)];
         end else if (t >= 64*H && t < 65*H) begin
            e_cs = 0; e_mosi = mframe[0];
         end
         if (t >= 0 && t < 16*H) mtagb = "R1";
         else mtagb = {mtag, "/R6"};
         chk(req_ready == e_rdy, "R8 ready", req_ready, e_rdy);
         chk(spi_cs_n == e_cs, "R7 cs_n", spi_cs_n, e_cs);
         chk(spi_sck == e_sck, "R6 sck", spi_sck, e_sck);
         chk(spi_mosi == e_mosi, {mtagb, " mosi"}, spi_mosi, e_mosi);
         if (spi_sck && !prev_sck && !spi_cs_n) cap_q.push_back(spi_mosi);
         if (req_ready && !prev_ready && mvalid_frame) begin
            logic [31:0] got = '0;
            foreach (cap_q[i]) got = {got[30:0], cap_q[i]};
            chk(cap_q.size() == 32, "R7 bit count", cap_q.size(), 32);
            chk(got == mframe, {mtag, " frame"}, got, mframe);
         end
         prev_sck = spi_sck;
         prev_ready = req_ready;
      end
   end

   task automatic wait_ready();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic send(bit blk, bit bin, int page, string tag, bit stray);
      wait_ready();
      drive_tag = tag;
      req_block = blk; req_bin_page = bin; req_page = 12'(page); req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      if (stray) begin
         // R9: requests while busy must be ignored
         repeat (20) @(negedge clk);
         drive_tag = "R9";
         req_block = !blk; req_bin_page = !bin; req_page = ~12'(page); req_valid = 1;
         repeat (30) @(negedge clk);
         req_valid = 0;
      end
      wait_ready();
   endtask

   initial begin
      // R10: outputs during reset
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1, "R10 cs_n", spi_cs_n, 1);
      chk(spi_sck == 0, "R10 sck", spi_sck, 0);
      chk(spi_mosi == 0, "R10 mosi", spi_mosi, 0);
      chk(req_ready == 1, "R10 ready", req_ready, 1);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1 && req_ready == 1, "R10 after reset", {spi_cs_n, req_ready}, 2'b11);

      send(0, 0, 'hABC, "R2", 0);
      send(0, 1, 'hABC, "R3", 0);
      send(1, 0, 'hABF, "R4", 0);
      send(1, 1, 'h007, "R5", 0);
      send(0, 0, 'hFFF, "R2", 0);
      send(0, 1, 'h000, "R3", 0);
      send(1, 1, 'hFFF, "R5", 0);
      send(1, 0, 'h5A3, "R4", 1);

      // R8: request held valid, taken again as soon as ready returns
      wait_ready();
      drive_tag = "R2";
      req_block = 0; req_bin_page = 0; req_page = 12'h123; req_valid = 1;
      @(negedge clk);
      drive_tag = "R8";
      req_block = 1; req_bin_page = 1; req_page = 12'h9C4;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      chk(req_ready == 0 && spi_cs_n == 0, "R8 back-to-back accept",
          {req_ready, spi_cs_n}, 2'b00);
      wait_ready();
      repeat (5) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 20000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule